// File: doc/BRIEF.md
# Fast-Control Broadcast Decoder with Reload Pulse Generator

This block sits at the head of a crate-wide fast-control bus. On each 40 MHz clock it may receive one broadcast byte with a valid flag, one individually addressed data byte with its own valid flag, and a level-1 accept bit. It splits the broadcast byte into a 6-bit command field and two counter-reset bits. It drives these onto the bus with a command strobe and flags bunch-crossing-zero when the command carries that code. The addressed data byte goes out with a data strobe.

Three command codes ask for a reload of one group of target boards: the processor group, the sorter group, or the peripheral group. A fourth code asks for a reload of all three. Each request becomes a hard-reset pulse of fixed length on the selected group's line. The configuration-done lines of all targets are registered and presented as one status vector.

Every output is registered. A broadcast byte sampled on one rising edge shows up on the bus exactly one cycle later.

Top module: `fastctl_hub`

## Requirements
- R1: One cycle after a valid broadcast byte B is sampled, `cmd_out` equals B[7:2], `evc_rst` equals B[1] and `bc_rst` equals B[0]. `cmd_out` holds its value while no valid byte arrives.
- R2: `cmd_stb` is high exactly in the cycle after a valid broadcast byte is sampled. In any cycle where `cmd_stb` is low, `evc_rst`, `bc_rst` and `bx0` are low.
- R3: `bx0` is high together with `cmd_stb` only when the command field equals 0x01.
- R4: `l1a_out` repeats `l1a_in` with one cycle of delay, unchanged.
- R5: `data_stb` is high exactly in the cycle after `addr_valid` is sampled high, and `data_out` then equals the sampled `addr_data`. `data_out` holds its value otherwise.
- R6: Command 0x1C drives `hard_rst[0]` (processor group) high for exactly `PULSE_CYC` cycles (default 16, which is 400 ns at 40 MHz), starting one cycle after the byte is sampled. The other groups stay low.
- R7: Command 0x1D drives only `hard_rst[1]` (sorter group) for `PULSE_CYC` cycles.
- R8: The command equal to parameter `PERI_CODE` (default 0x1E) drives only `hard_rst[2]` (peripheral group) for `PULSE_CYC` cycles.
- R9: Command 0x04 drives all three `hard_rst` bits high in the same cycles, each for `PULSE_CYC` cycles.
- R10: A request for a group whose pulse is still active restarts its count. The pulse then ends `PULSE_CYC` cycles after the later request.
- R11: Any other command code is still placed on `cmd_out` with `cmd_stb`, but raises no `hard_rst` bit.
- R12: `done_q` equals `done_in` delayed by one cycle.
- R13: While `rst` is high and in the first cycle after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| bc_byte | input | 8 | Broadcast byte: command field in bits 7:2, event-counter reset in bit 1, bunch-counter reset in bit 0 |
| bc_valid | input | 1 | Broadcast byte valid this cycle |
| addr_data | input | 8 | Individually addressed data byte |
| addr_valid | input | 1 | Addressed data valid this cycle |
| l1a_in | input | 1 | Level-1 accept |
| done_in | input | NUM_TGT | Configuration-done line of each target |
| cmd_out | output | 6 | Command field on the bus |
| cmd_stb | output | 1 | Command strobe |
| evc_rst | output | 1 | Event-counter reset |
| bc_rst | output | 1 | Bunch-counter reset |
| bx0 | output | 1 | Bunch-crossing-zero marker |
| l1a_out | output | 1 | Level-1 accept to the bus |
| data_out | output | 8 | Addressed data on the bus |
| data_stb | output | 1 | Data strobe |
| hard_rst | output | 3 | Reload pulses: bit 0 processor, bit 1 sorter, bit 2 peripheral group |
| done_q | output | NUM_TGT | Registered view of the done lines |

## Verification
The bench builds the block with the default pulse length of 16 cycles and the default peripheral code, but with `NUM_TGT` set to 4. With these values it can sweep all 256 broadcast bytes and all 256 data bytes, and every pattern of the done lines. For each broadcast byte it measures the full length of each group's pulse, so every reload code and every inert code is covered. It also runs a restart test and an alternating level-1 accept pattern.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 6;
  localparam int GROUPS = 3;

  localparam logic [CMD_W-1:0] CODE_BX0        = 6'h01;
  localparam logic [CMD_W-1:0] CODE_RELOAD_ALL = 6'h04;
  localparam logic [CMD_W-1:0] CODE_PROC       = 6'h1C;
  localparam logic [CMD_W-1:0] CODE_SORT       = 6'h1D;

  localparam int GRP_PROC = 0;
  localparam int GRP_SORT = 1;
  localparam int GRP_PERI = 2;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic             evc;
    logic             bcr;
  } bc_fields_t;
endpackage

// File: rtl/fc_bus_reg.sv
module fc_bus_reg
  import fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] bc_byte,
  input  logic              bc_valid,
  input  logic [BYTE_W-1:0] addr_data,
  input  logic              addr_valid,
  input  logic              l1a_in,
  output logic [CMD_W-1:0]  cmd_out,
  output logic              cmd_stb,
  output logic              evc_rst,
  output logic              bc_rst,
  output logic              bx0,
  output logic              l1a_out,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_stb
);
  bc_fields_t f;
  assign f = bc_fields_t'(bc_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_out  <= '0;
      cmd_stb  <= 1'b0;
      evc_rst  <= 1'b0;
      bc_rst   <= 1'b0;
      bx0      <= 1'b0;
      l1a_out  <= 1'b0;
      data_out <= '0;
      data_stb <= 1'b0;
    end else begin
      cmd_stb  <= bc_valid;
      evc_rst  <= bc_valid & f.evc;
      bc_rst   <= bc_valid & f.bcr;
      bx0      <= bc_valid && (f.cmd == CODE_BX0);
      if (bc_valid) cmd_out <= f.cmd;
      l1a_out  <= l1a_in;
      data_stb <= addr_valid;
      if (addr_valid) data_out <= addr_data;
    end
  end
endmodule

// File: rtl/fc_reload_decode.sv
module fc_reload_decode
  import fc_pkg::*;
#(
  parameter logic [5:0] PERI_CODE = 6'h1E
) (
  input  logic [CMD_W-1:0]  cmd,
  input  logic              valid,
  output logic [GROUPS-1:0] trig
);
  always_comb begin
    trig = '0;
    if (valid) begin
      if (cmd == CODE_RELOAD_ALL) trig = '1;
      if (cmd == CODE_PROC)       trig[GRP_PROC] = 1'b1;
      if (cmd == CODE_SORT)       trig[GRP_SORT] = 1'b1;
      if (cmd == PERI_CODE)       trig[GRP_PERI] = 1'b1;
    end
  end
endmodule

// File: rtl/fc_pulse_gen.sv
module fc_pulse_gen #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_CYC - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      pulse  <= 1'b0;
    end else if (trig) begin
      remain <= RELOAD;
      pulse  <= 1'b1;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else begin
      pulse  <= 1'b0;
    end
  end
endmodule

// File: rtl/fc_done_view.sv
module fc_done_view #(
  parameter int NUM_TGT = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_TGT-1:0] done_in,
  output logic [NUM_TGT-1:0] done_q
);
  always_ff @(posedge clk) begin
    if (rst) done_q <= '0;
    else     done_q <= done_in;
  end
endmodule

// File: rtl/fastctl_hub.sv
module fastctl_hub
  import fc_pkg::*;
#(
  parameter int         NUM_TGT   = 16,
  parameter int         PULSE_CYC = 16,
  parameter logic [5:0] PERI_CODE = 6'h1E
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         bc_byte,
  input  logic               bc_valid,
  input  logic [7:0]         addr_data,
  input  logic               addr_valid,
  input  logic               l1a_in,
  input  logic [NUM_TGT-1:0] done_in,
  output logic [5:0]         cmd_out,
  output logic               cmd_stb,
  output logic               evc_rst,
  output logic               bc_rst,
  output logic               bx0,
  output logic               l1a_out,
  output logic [7:0]         data_out,
  output logic               data_stb,
  output logic [2:0]         hard_rst,
  output logic [NUM_TGT-1:0] done_q
);
  logic [GROUPS-1:0] trig;

  fc_bus_reg u_bus (
    .clk(clk), .rst(rst), .bc_byte(bc_byte), .bc_valid(bc_valid),
    .addr_data(addr_data), .addr_valid(addr_valid), .l1a_in(l1a_in),
    .cmd_out(cmd_out), .cmd_stb(cmd_stb), .evc_rst(evc_rst), .bc_rst(bc_rst),
    .bx0(bx0), .l1a_out(l1a_out), .data_out(data_out), .data_stb(data_stb)
  );

  fc_reload_decode #(.PERI_CODE(PERI_CODE)) u_dec (
    .cmd(bc_byte[7:2]), .valid(bc_valid), .trig(trig)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_pulse
    fc_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pg (
      .clk(clk), .rst(rst), .trig(trig[g]), .pulse(hard_rst[g])
    );
  end

  fc_done_view #(.NUM_TGT(NUM_TGT)) u_done (
    .clk(clk), .rst(rst), .done_in(done_in), .done_q(done_q)
  );
endmodule

// File: rtl/fastctl_hub_chk.sv
module fastctl_hub_chk #(
  parameter int         NUM_TGT   = 16,
  parameter int         PULSE_CYC = 16,
  parameter logic [5:0] PERI_CODE = 6'h1E
) (
  input logic               clk,
  input logic               rst,
  input logic [7:0]         bc_byte,
  input logic               bc_valid,
  input logic [7:0]         addr_data,
  input logic               addr_valid,
  input logic               l1a_in,
  input logic [NUM_TGT-1:0] done_in,
  input logic [5:0]         cmd_out,
  input logic               cmd_stb,
  input logic               evc_rst,
  input logic               bc_rst,
  input logic               bx0,
  input logic               l1a_out,
  input logic [7:0]         data_out,
  input logic               data_stb,
  input logic [2:0]         hard_rst,
  input logic [NUM_TGT-1:0] done_q
);
  localparam int SW = $clog2(PULSE_CYC + 1);
  localparam logic [5:0] GCODE [3] = '{6'h1C, 6'h1D, PERI_CODE};

  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  a_r1_fields: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && cmd_stb) |-> (cmd_out == $past(bc_byte[7:2]) &&
                               evc_rst == $past(bc_byte[1]) &&
                               bc_rst  == $past(bc_byte[0])));
  a_r2_stb: assert property (@(posedge clk) disable iff (rst)
    !was_rst |-> (cmd_stb == $past(bc_valid)));
  a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
    !cmd_stb |-> (!evc_rst && !bc_rst && !bx0));
  a_r3_bx0: assert property (@(posedge clk) disable iff (rst)
    bx0 |-> (cmd_stb && cmd_out == 6'h01));
  a_r4_l1a: assert property (@(posedge clk) disable iff (rst)
    !was_rst |-> (l1a_out == $past(l1a_in)));
  a_r5_data: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && $past(addr_valid)) |-> (data_stb && data_out == $past(addr_data)));
  a_r9_all: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && $past(bc_valid && bc_byte[7:2] == 6'h04)) |-> (hard_rst == 3'b111));
  a_r12_done: assert property (@(posedge clk) disable iff (rst)
    !was_rst |-> (done_q == $past(done_in)));

  for (genvar g = 0; g < 3; g++) begin : g_len
    logic [SW-1:0] since;
    logic          hit;
    assign hit = bc_valid && (bc_byte[7:2] == 6'h04 || bc_byte[7:2] == GCODE[g]);
    always_ff @(posedge clk) begin
      if (rst)                           since <= SW'(PULSE_CYC);
      else if (hit)                      since <= '0;
      else if (since != SW'(PULSE_CYC)) since <= since + 1'b1;
    end
    // R6 R7 R8 R10 R11: pulse high exactly while fewer than PULSE_CYC cycles since last request
    a_r6_pulse_len: assert property (@(posedge clk) disable iff (rst)
      !was_rst |-> (hard_rst[g] == (since < SW'(PULSE_CYC))));
  end
endmodule

bind fastctl_hub fastctl_hub_chk #(
  .NUM_TGT(NUM_TGT), .PULSE_CYC(PULSE_CYC), .PERI_CODE(PERI_CODE)
) u_chk (.*);

// File: tb/tb_fastctl_hub.sv
`timescale 1ns/1ps
module tb_fastctl_hub;
  localparam int NT = 4;
  localparam int PC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bc_byte = '0;
  logic bc_valid = 1'b0;
  logic [7:0] addr_data = '0;
  logic addr_valid = 1'b0;
  logic l1a_in = 1'b0;
  logic [NT-1:0] done_in = '0;
  logic [5:0] cmd_out;
  logic cmd_stb, evc_rst, bc_rst, bx0, l1a_out, data_stb;
  logic [7:0] data_out;
  logic [2:0] hard_rst;
  logic [NT-1:0] done_q;

  int errors = 0;
  int checks = 0;
  int hi_cnt [3];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fastctl_hub #(.NUM_TGT(NT), .PULSE_CYC(PC)) dut (.*);

  always @(posedge clk) begin
    #1;
    for (int g = 0; g < 3; g++) if (hard_rst[g]) hi_cnt[g]++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_cnt();
    for (int g = 0; g < 3; g++) hi_cnt[g] = 0;
  endtask

  function automatic logic [2:0] exp_mask(input logic [5:0] c);
    if (c == 6'h04) return 3'b111;
    if (c == 6'h1C) return 3'b001;
    if (c == 6'h1D) return 3'b010;
    if (c == 6'h1E) return 3'b100;
    return 3'b000;
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk({cmd_out, cmd_stb, evc_rst, bc_rst, bx0, l1a_out, data_out, data_stb, hard_rst, done_q} == '0,
        "R13 reset", int'(cmd_stb), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({cmd_stb, hard_rst, data_stb} == '0, "R13 after reset", int'(hard_rst), 0);

    // broadcast sweep: R1 R2 R3 R6 R7 R8 R9 R11
    for (int b = 0; b < 256; b++) begin
      logic [5:0] c;
      logic [2:0] m;
      c = 6'(b >> 2);
      m = exp_mask(c);
      clr_cnt();
      bc_byte = 8'(b); bc_valid = 1'b1;
      @(negedge clk);
      bc_valid = 1'b0;
      chk(cmd_stb == 1'b1, "R2 strobe", int'(cmd_stb), 1);
      chk(cmd_out == c, "R1 cmd", int'(cmd_out), int'(c));
      chk(evc_rst == b[1] && bc_rst == b[0], "R1 reset bits",
          int'({evc_rst, bc_rst}), b & 3);
      chk(bx0 == (c == 6'h01), "R3 bx0", int'(bx0), int'(c == 6'h01));
      chk(hard_rst == m, "R9 simultaneous start", int'(hard_rst), int'(m));
      @(negedge clk);
      chk({cmd_stb, evc_rst, bc_rst, bx0} == 4'b0, "R2 quiet", int'({cmd_stb, evc_rst, bc_rst, bx0}), 0);
      chk(cmd_out == c, "R1 hold", int'(cmd_out), int'(c));
      repeat (18) @(negedge clk);
      for (int g = 0; g < 3; g++) begin
        int e;
        e = m[g] ? PC : 0;
        if (m == 3'b111)      chk(hi_cnt[g] == e, "R9 len", hi_cnt[g], e);
        else if (g == 0)      chk(hi_cnt[g] == e, "R6 len", hi_cnt[g], e);
        else if (g == 1)      chk(hi_cnt[g] == e, "R7 len", hi_cnt[g], e);
        else                  chk(hi_cnt[g] == e, "R8 len", hi_cnt[g], e);
        if (m == 3'b000) chk(hi_cnt[g] == 0, "R11 no pulse", hi_cnt[g], 0);
      end
    end

    // R10: restart while active
    clr_cnt();
    @(negedge clk); bc_byte = {6'h1C, 2'b00}; bc_valid = 1'b1;
    @(negedge clk); bc_valid = 1'b0;
    repeat (9) @(negedge clk);
    bc_valid = 1'b1;
    @(negedge clk); bc_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(hi_cnt[0] == 10 + PC, "R10 restart", hi_cnt[0], 10 + PC);
    chk(hi_cnt[1] == 0 && hi_cnt[2] == 0, "R10 others", hi_cnt[1] + hi_cnt[2], 0);

    // R5: data sweep
    for (int d = 0; d < 256; d++) begin
      @(negedge clk); addr_data = 8'(d); addr_valid = 1'b1;
      @(negedge clk); addr_valid = 1'b0; addr_data = 8'(~d);
      chk(data_stb && data_out == 8'(d), "R5 data", int'(data_out), d);
    end
    @(negedge clk);
    chk(!data_stb && data_out == 8'hFF, "R5 hold", int'({data_stb, data_out}), 8'hFF);

    // R4: level-1 accept pattern
    begin
      logic [7:0] pat;
      pat = 8'b1011_0010;
      for (int i = 0; i < 8; i++) begin
        l1a_in = pat[i];
        @(negedge clk);
        chk(l1a_out == pat[i], "R4 l1a", int'(l1a_out), int'(pat[i]));
      end
      l1a_in = 1'b0;
    end

    // R12: done view sweep
    for (int p = 0; p < (1 << NT); p++) begin
      done_in = NT'(p);
      @(negedge clk);
      chk(done_q == NT'(p), "R12 done", int'(done_q), p);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule